// File: doc/BRIEF.md
# Bit-Addressable GPIO Port with Read-Modify-Write Sequencer

An eight-pin general-purpose I/O port with two registers: a direction register that software can write but never read back, and a data register. A small sequencer sets or clears one bit of either register by reading the register over the internal bus, changing the one bit, and writing the byte back.

The direction register returns all ones on every read. A bit operation aimed at it therefore writes back ones into every other position. Any pin that was an input becomes an output. The block keeps this hazard exact to the cycle, so that firmware and models built on it meet the same behaviour.

A host port writes either register directly and reads either register with one cycle of latency. External pin levels pass through a synchroniser before any read can see them.

Top module: `gpio_bitop_port`

## Requirements
- R1: While `rst` is high at a clock edge, both registers clear to zero. After reset, `pin_oe` and `pin_out` are 8'h00, and `busy` and `done` are 0.
- R2: When `host_we` is high and `busy` is low, `host_wdata` is written at the clock edge. The target is the data register when `host_sel`=0 and the direction register when `host_sel`=1. `pin_oe` shows the direction register (1 = output) and `pin_out` shows the data register.
- R3: A host read (`host_re`=1) with `host_sel`=1 returns 8'hFF on `host_rdata` one cycle later, whatever the direction register holds.
- R4: A host read with `host_sel`=0 returns, for each bit, the data register bit where the direction bit is 1 and the synchronised pin level where it is 0.
- R5: `cmd_set`=0 requests a clear. The sequencer reads the target through the same view as R3/R4 (`cmd_sel` 0 = data, 1 = direction), forces bit `cmd_idx` to 0, and writes the byte back. Clearing bit 0 of direction 8'h3F leaves 8'hFE.
- R6: `cmd_set`=1 performs the same sequence but forces bit `cmd_idx` to 1.
- R7: A command is accepted at an edge where `cmd_valid` is high and `busy` is low. `busy` is then high for exactly three cycles. The writeback lands at the edge that drops `busy`, and `done` is high for exactly the following cycle.
- R8: While `busy` is high, `cmd_valid` and `host_we` have no effect.
- R9: A change on `pin_in` reaches the data-register read view after `SYNC_STAGES` (default 2) clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe |
| host_sel | input | 1 | Register select: 0 data, 1 direction |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| cmd_valid | input | 1 | Bit-operation request |
| cmd_set | input | 1 | 1 set, 0 clear |
| cmd_sel | input | 1 | Target register: 0 data, 1 direction |
| cmd_idx | input | 3 | Bit index |
| busy | output | 1 | Sequencer running |
| done | output | 1 | One-cycle completion pulse |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin output enables |

## Verification
The bench aims first at the all-ones readback hazard. It clears one bit of a partly-input direction register and expects every other direction bit to become 1. A design that read the true register contents would leave those pins as inputs.

Bit operations on the data register are run with mixed directions and a fixed external pattern. A design that read back the latch instead of the pin level would write the wrong input bits.

Commands and host writes issued while `busy` is high must leave no trace. A design that queued them would change `pin_oe` after `done`.

The synchroniser latency is measured edge by edge. An unsynchronised path would show the new level one or two cycles early.

// File: rtl/gpio_bitop_pkg.sv
package gpio_bitop_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_FETCH  = 2'd1,
    SQ_MODIFY = 2'd2,
    SQ_STORE  = 2'd3
  } seq_state_e;

  localparam logic SEL_DATA = 1'b0;
  localparam logic SEL_DIR  = 1'b1;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= async_in;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bitop_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             seq_rsel,
  output logic [WIDTH-1:0] seq_rdata,
  input  logic             host_re,
  input  logic             host_rsel,
  output logic [WIDTH-1:0] host_rdata,
  input  logic [WIDTH-1:0] pin_level,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] data_q
);
  function automatic logic [WIDTH-1:0] view(input logic sel,
                                            input logic [WIDTH-1:0] d,
                                            input logic [WIDTH-1:0] o,
                                            input logic [WIDTH-1:0] p);
    if (sel == SEL_DIR) view = '1;
    else view = (d & o) | (~d & p);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      data_q <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_DIR) dir_q <= wr_data;
      else data_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else if (host_re) host_rdata <= view(host_rsel, dir_q, data_q, pin_level);
  end

  assign seq_rdata = view(seq_rsel, dir_q, data_q, pin_level);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (dir_q == '0 && data_q == '0));

  assert_dir_reads_ones_R3: assert property (@(posedge clk) disable iff (rst)
    (host_re && host_rsel == SEL_DIR) |=> (host_rdata == '1));

  assert_no_write_no_change_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(dir_q) && $stable(data_q)));
endmodule

// File: rtl/gpio_bitop_seq.sv
module gpio_bitop_seq
  import gpio_bitop_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_set,
  input  logic             cmd_sel,
  input  logic [IW-1:0]    cmd_idx,
  output logic             busy,
  output logic             done,
  output logic             bus_sel,
  input  logic [WIDTH-1:0] bus_rdata,
  output logic             bus_we,
  output logic [WIDTH-1:0] bus_wdata
);
  seq_state_e       st;
  logic             op_set;
  logic             op_sel;
  logic [IW-1:0]    op_idx;
  logic [WIDTH-1:0] rd_cap;
  logic [WIDTH-1:0] wr_val;
  logic [WIDTH-1:0] mask;

  assign mask = WIDTH'(1) << op_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SQ_IDLE;
      op_set <= 1'b0;
      op_sel <= SEL_DATA;
      op_idx <= '0;
      rd_cap <= '0;
      wr_val <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SQ_IDLE: if (cmd_valid) begin
          op_set <= cmd_set;
          op_sel <= cmd_sel;
          op_idx <= cmd_idx;
          st     <= SQ_FETCH;
        end
        SQ_FETCH: begin
          rd_cap <= bus_rdata;
          st     <= SQ_MODIFY;
        end
        SQ_MODIFY: begin
          wr_val <= op_set ? (rd_cap | mask) : (rd_cap & ~mask);
          st     <= SQ_STORE;
        end
        SQ_STORE: begin
          done <= 1'b1;
          st   <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (st != SQ_IDLE);
  assign bus_sel   = op_sel;
  assign bus_we    = (st == SQ_STORE);
  assign bus_wdata = wr_val;

  assert_store_then_done_R7: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> (done && !busy));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_one_bit_changed_R5: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> ($countones(wr_val ^ rd_cap) <= 1));

  assert_target_bit_forced_R6: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> (wr_val[op_idx] == op_set));

  assert_cmd_latched_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !bus_we) |=> ($stable(op_idx) && $stable(op_set) && $stable(op_sel)));
endmodule

// File: rtl/gpio_bitop_port.sv
module gpio_bitop_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic             host_re,
  input  logic             host_sel,
  input  logic [WIDTH-1:0] host_wdata,
  output logic [WIDTH-1:0] host_rdata,
  input  logic             cmd_valid,
  input  logic             cmd_set,
  input  logic             cmd_sel,
  input  logic [IW-1:0]    cmd_idx,
  output logic             busy,
  output logic             done,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  logic [WIDTH-1:0] pin_level;
  logic             seq_sel;
  logic [WIDTH-1:0] seq_rdata;
  logic             seq_we;
  logic [WIDTH-1:0] seq_wdata;
  logic             bus_we;
  logic             bus_wsel;
  logic [WIDTH-1:0] bus_wdata;

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_level)
  );

  gpio_bitop_seq #(.WIDTH(WIDTH)) u_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_set(cmd_set), .cmd_sel(cmd_sel), .cmd_idx(cmd_idx),
    .busy(busy), .done(done),
    .bus_sel(seq_sel), .bus_rdata(seq_rdata),
    .bus_we(seq_we), .bus_wdata(seq_wdata)
  );

  assign bus_we    = seq_we | (host_we & ~busy);
  assign bus_wsel  = busy ? seq_sel : host_sel;
  assign bus_wdata = busy ? seq_wdata : host_wdata;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(bus_we), .wr_sel(bus_wsel), .wr_data(bus_wdata),
    .seq_rsel(seq_sel), .seq_rdata(seq_rdata),
    .host_re(host_re), .host_rsel(host_sel), .host_rdata(host_rdata),
    .pin_level(pin_level),
    .dir_q(pin_oe), .data_q(pin_out)
  );

  assert_busy_blocks_host_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !seq_we) |=> ($stable(pin_oe) && $stable(pin_out)));

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done));
endmodule

// File: tb/test_gpio_bitop_port.sv
module test_gpio_bitop_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] EXT = 8'hA5;

  logic clk = 1'b0;
  logic rst;
  logic host_we, host_re, host_sel;
  logic [7:0] host_wdata, host_rdata;
  logic cmd_valid, cmd_set, cmd_sel;
  logic [2:0] cmd_idx;
  logic busy, done;
  logic [7:0] pin_in, pin_out, pin_oe;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bitop_port i_gpio_bitop_port (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_re(host_re), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_valid(cmd_valid), .cmd_set(cmd_set), .cmd_sel(cmd_sel), .cmd_idx(cmd_idx),
    .busy(busy), .done(done),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {set, sel, idx[2:0], dir preset, data preset, expected target value}
  localparam logic [28:0] VEC [7] = '{
    {1'b0, 1'b1, 3'd0, 8'h3F, 8'h00, 8'hFE},
    {1'b1, 1'b1, 3'd3, 8'h00, 8'h5A, 8'hFF},
    {1'b0, 1'b1, 3'd7, 8'hFF, 8'h33, 8'h7F},
    {1'b0, 1'b0, 3'd2, 8'h0F, 8'h3C, 8'hA8},
    {1'b1, 1'b0, 3'd6, 8'hFF, 8'h00, 8'h40},
    {1'b1, 1'b0, 3'd0, 8'h00, 8'h00, 8'hA5},
    {1'b0, 1'b0, 3'd5, 8'hF0, 8'h0F, 8'h05}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic [7:0] val);
    host_we = 1'b1; host_sel = sel; host_wdata = val;
    step();
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic sel, output logic [7:0] val);
    host_re = 1'b1; host_sel = sel;
    step();
    host_re = 1'b0;
    val = host_rdata;
  endtask

  task automatic run_cmd(input logic set, input logic sel, input logic [2:0] idx);
    cmd_valid = 1'b1; cmd_set = set; cmd_sel = sel; cmd_idx = idx;
    step();
    cmd_valid = 1'b0;
    step(); step(); step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rst = 1'b1; host_we = 0; host_re = 0; host_sel = 0; host_wdata = 0;
    cmd_valid = 0; cmd_set = 0; cmd_sel = 0; cmd_idx = 0; pin_in = EXT;
    @(negedge clk); step(); step();
    rst = 1'b0;
    // R1 reset state
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_out, 8'h00);
    check("R1 busy/done", {6'd0, busy, done}, 8'h00);

    // Vector table: R2 presets, R5/R6 bit operations
    foreach (VEC[i]) begin
      host_write(1'b1, VEC[i][23:16]);
      host_write(1'b0, VEC[i][15:8]);
      check("R2 preset dir", pin_oe, VEC[i][23:16]);
      run_cmd(VEC[i][28], VEC[i][27], VEC[i][26:24]);
      if (VEC[i][27]) begin
        check(VEC[i][28] ? "R6 set dir" : "R5 clear dir", pin_oe, VEC[i][7:0]);
        check("R5 data untouched", pin_out, VEC[i][15:8]);
      end else begin
        check(VEC[i][28] ? "R6 set data" : "R5 clear data", pin_out, VEC[i][7:0]);
        check("R5 dir untouched", pin_oe, VEC[i][23:16]);
      end
      step();
    end

    // R3 direction readback
    host_write(1'b1, 8'h3F);
    host_read(1'b1, r);
    check("R3 dir read", r, 8'hFF);
    // R4 mixed data read: dir 3F, data 0x96, pins A5
    host_write(1'b0, 8'h96);
    host_read(1'b0, r);
    check("R4 data read", r, 8'h96 & 8'h3F | EXT & 8'hC0);

    // R7 busy/done timing
    cmd_valid = 1'b1; cmd_set = 1'b0; cmd_sel = 1'b1; cmd_idx = 3'd0;
    step();
    cmd_valid = 1'b0;
    check("R7 busy c1", {7'd0, busy}, 8'h01);
    step();
    check("R7 busy c2", {7'd0, busy}, 8'h01);
    step();
    check("R7 busy c3 no early write", {busy, pin_oe[6:0]}, {1'b1, 7'h3F});
    step();
    check("R7 busy drop/done", {6'd0, busy, done}, 8'h01);
    check("R5 hazard 3F->FE", pin_oe, 8'hFE);
    step();
    check("R7 done single", {7'd0, done}, 8'h00);

    // R8 ignore while busy
    host_write(1'b1, 8'h00);
    cmd_valid = 1'b1; cmd_set = 1'b0; cmd_sel = 1'b1; cmd_idx = 3'd2;
    step();
    cmd_set = 1'b0; cmd_idx = 3'd5; host_we = 1'b1; host_sel = 1'b1; host_wdata = 8'h11;
    step();
    cmd_valid = 1'b0; host_we = 1'b0;
    step(); step();
    check("R8 busy-time inputs ignored", pin_oe, 8'hFB);
    step(); step();
    check("R8 no second command", {6'd0, busy, done}, 8'h00);
    check("R8 dir after idle", pin_oe, 8'hFB);

    // R9 synchroniser latency (dir all input)
    host_write(1'b1, 8'h00);
    pin_in = 8'h00;
    step(); step(); step();
    pin_in = 8'hFF; host_re = 1'b1; host_sel = 1'b0;
    step();
    check("R9 edge1 old", host_rdata, 8'h00);
    step();
    check("R9 edge2 old", host_rdata, 8'h00);
    step();
    check("R9 edge3 new", host_rdata, 8'hFF);
    host_re = 1'b0;

    // R1 reset mid-command
    cmd_valid = 1'b1; cmd_set = 1'b1; cmd_sel = 1'b0; cmd_idx = 3'd1;
    step();
    cmd_valid = 1'b0; rst = 1'b1;
    step();
    rst = 1'b0;
    check("R1 reset clears", {pin_oe | pin_out}, 8'h00);
    check("R1 reset idles", {6'd0, busy, done}, 8'h00);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule